// File: doc/BRIEF.md
# Cascadable Sum-of-Products Logic Cell

This block is the combinational heart of a programmable logic cell. A set of true input signals, split into a global group and a regional group, is expanded into a literal bus that holds every signal in both true and complemented form. Each of a fixed number of product terms ANDs together the literals picked by its own configuration mask. A per-term steering bit decides whether the term feeds the local OR. The OR result can be widened by a cascade input from a neighbouring cell, and the widened sum leaves the cell as the cascade output. It also enters an XOR stage whose second input is either a chosen product term or a constant. A constant one gives inverted output polarity.

Beside the main path, the cell emits a foldback signal, which is the inverse of a chosen product term, for a shared regional bus. It also emits a separate data term, which is a chosen product term taken off for a downstream register whether or not that term also feeds the OR. All configuration is static input bits. A parameter removes the cascade input from the logic altogether.

Top module: `sop_cell`

## Requirements
- R1: Signals form the vector sig = {rgn_in, glb_in} (glb_in in the low bits). Literal i for i < S is sig[i], and literal S+i is ~sig[i], where S = GLB_W+REG_W. Product term k is the AND of every literal whose bit is set in cfg_mask[k*2S +: 2S].
- R2: A product term whose mask field is all zero evaluates to 1.
- R3: The local sum is the OR of the product terms whose cfg_or_en bit is 1. A term with its bit at 0 contributes 0.
- R4: With CASC_EN=1, casc_out equals the local sum ORed with casc_in.
- R5: cfg_pol selects the second XOR input: 0 gives constant 0 (cell_out = casc_out), 1 gives constant 1 (cell_out = ~casc_out), 2 gives product term cfg_xsel, and 3 behaves as 0.
- R6: fold_out equals the inverse of product term cfg_fsel.
- R7: dat_out equals product term cfg_dsel, whatever the value of cfg_or_en.
- R8: A select value of NT or more picks logic 0 in place of a term, so fold_out becomes 1 and dat_out becomes 0.
- R9: With CASC_EN=0, casc_in has no effect, and casc_out equals the local sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| glb_in | input | GLB_W | Global signals, true form |
| rgn_in | input | REG_W | Regional signals, true form |
| casc_in | input | 1 | Sum from the neighbouring cell |
| cfg_mask | input | NT*2*(GLB_W+REG_W) | Literal masks, one field per term |
| cfg_or_en | input | NT | Steers each term into the OR |
| cfg_pol | input | 2 | XOR second-input mode |
| cfg_xsel | input | SEL_W | Term index for XOR mode 2 |
| cfg_fsel | input | SEL_W | Term index for foldback |
| cfg_dsel | input | SEL_W | Term index for data term |
| cell_out | output | 1 | XOR stage result |
| casc_out | output | 1 | Local sum ORed with cascade input |
| fold_out | output | 1 | Inverted selected term |
| dat_out | output | 1 | Selected term for a register input |

## Verification
The cell has no state, so any wrong literal ordering, mask decode or steering shows up at once on some output under the input pattern that exercises it. The bench sweeps every input combination against many configurations, including empty masks, out-of-range selects and all polarity modes. A fault that affects only one literal or one term therefore shows on the first vector where that literal or term decides the sum. A second instance built without the cascade shows whether casc_in leaks into the result.

// File: rtl/sop_cell_pkg.sv
package sop_cell_pkg;

   typedef enum logic [1:0] {
      POL_ZERO = 2'd0,
      POL_ONE  = 2'd1,
      POL_TERM = 2'd2,
      POL_RSVD = 2'd3
   } pol_e;

   function automatic int sel_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/sop_lit_bus.sv
module sop_lit_bus #(
   parameter int GLB_W = 34,
   parameter int REG_W = 16,
   localparam int SIG_W = GLB_W + REG_W,
   localparam int LIT_W = 2 * SIG_W
) (
   input  logic [GLB_W-1:0] glb_in,
   input  logic [REG_W-1:0] rgn_in,
   output logic [LIT_W-1:0] lit
);

   logic [SIG_W-1:0] sig;

   assign sig = {rgn_in, glb_in};

   // true forms low, complements high
   genvar gi;
   generate
      for (gi = 0; gi < SIG_W; gi++) begin : g_lit
         assign lit[gi]         = sig[gi];
         assign lit[SIG_W + gi] = ~sig[gi];
      end
   endgenerate

endmodule

// File: rtl/sop_pterm.sv
module sop_pterm #(
   parameter int LIT_W = 100
) (
   input  logic [LIT_W-1:0] lit,
   input  logic [LIT_W-1:0] mask,
   output logic             term
);

   // unselected literals are forced high, so an empty mask yields 1
   assign term = &(lit | ~mask);

   always_comb begin
      if (mask == '0) begin
         AST_EMPTY_MASK_HIGH: assert (term == 1'b1)
            else $error("empty mask term not high"); // R2
      end
   end

endmodule

// File: rtl/sop_term_pick.sv
module sop_term_pick #(
   parameter int NT    = 5,
   parameter int SEL_W = 3
) (
   input  logic [NT-1:0]    terms,
   input  logic [SEL_W-1:0] sel,
   output logic             picked
);

   always_comb begin
      picked = 1'b0;
      for (int k = 0; k < NT; k++) begin
         if (int'(sel) == k) picked = terms[k];
      end
   end

endmodule

// File: rtl/sop_sum_stage.sv
module sop_sum_stage
   import sop_cell_pkg::*;
#(
   parameter int NT      = 5,
   parameter bit CASC_EN = 1'b1
) (
   input  logic [NT-1:0] terms,
   input  logic [NT-1:0] or_en,
   input  logic          casc_in,
   input  logic [1:0]    pol,
   input  logic          xor_term,
   output logic          local_sum,
   output logic          casc_out,
   output logic          cell_out
);

   logic xor_b;

   assign local_sum = |(terms & or_en);

   generate
      if (CASC_EN) begin : g_casc
         assign casc_out = local_sum | casc_in;
      end else begin : g_nocasc
         logic unused_casc;
         assign unused_casc = casc_in;
         assign casc_out    = local_sum;
      end
   endgenerate

   always_comb begin
      case (pol_e'(pol))
         POL_ONE:  xor_b = 1'b1;
         POL_TERM: xor_b = xor_term;
         default:  xor_b = 1'b0;
      endcase
   end

   assign cell_out = casc_out ^ xor_b;

endmodule

// File: rtl/sop_cell.sv
module sop_cell
   import sop_cell_pkg::*;
#(
   parameter int GLB_W   = 34,
   parameter int REG_W   = 16,
   parameter int NT      = 5,
   parameter bit CASC_EN = 1'b1,
   parameter int SEL_W   = sop_cell_pkg::sel_width(NT)
) (
   input  logic [GLB_W-1:0]                  glb_in,
   input  logic [REG_W-1:0]                  rgn_in,
   input  logic                              casc_in,
   input  logic [NT*2*(GLB_W+REG_W)-1:0]     cfg_mask,
   input  logic [NT-1:0]                     cfg_or_en,
   input  logic [1:0]                        cfg_pol,
   input  logic [SEL_W-1:0]                  cfg_xsel,
   input  logic [SEL_W-1:0]                  cfg_fsel,
   input  logic [SEL_W-1:0]                  cfg_dsel,
   output logic                              cell_out,
   output logic                              casc_out,
   output logic                              fold_out,
   output logic                              dat_out
);

   localparam int SIG_W = GLB_W + REG_W;
   localparam int LIT_W = 2 * SIG_W;

   generate
      if (GLB_W < 1 || REG_W < 1) begin : g_bad_width
         $error("sop_cell: bus widths must be at least 1");
      end
      if (NT < 1) begin : g_bad_nt
         $error("sop_cell: at least one product term required");
      end
      if ((1 << SEL_W) < NT) begin : g_bad_sel
         $error("sop_cell: SEL_W too narrow for NT");
      end
   endgenerate

   logic [LIT_W-1:0] lit;
   logic [NT-1:0]    terms;
   logic             xor_term;
   logic             fold_term;
   logic             local_sum;

   sop_lit_bus #(.GLB_W(GLB_W), .REG_W(REG_W)) u_lit (
      .glb_in (glb_in),
      .rgn_in (rgn_in),
      .lit    (lit)
   );

   genvar tk;
   generate
      for (tk = 0; tk < NT; tk++) begin : g_term
         sop_pterm #(.LIT_W(LIT_W)) u_pt (
            .lit  (lit),
            .mask (cfg_mask[tk*LIT_W +: LIT_W]),
            .term (terms[tk])
         );
      end
   endgenerate

   sop_term_pick #(.NT(NT), .SEL_W(SEL_W)) u_pick_x (
      .terms (terms), .sel (cfg_xsel), .picked (xor_term)
   );
   sop_term_pick #(.NT(NT), .SEL_W(SEL_W)) u_pick_f (
      .terms (terms), .sel (cfg_fsel), .picked (fold_term)
   );
   sop_term_pick #(.NT(NT), .SEL_W(SEL_W)) u_pick_d (
      .terms (terms), .sel (cfg_dsel), .picked (dat_out)
   );

   assign fold_out = ~fold_term;

   sop_sum_stage #(.NT(NT), .CASC_EN(CASC_EN)) u_sum (
      .terms     (terms),
      .or_en     (cfg_or_en),
      .casc_in   (casc_in),
      .pol       (cfg_pol),
      .xor_term  (xor_term),
      .local_sum (local_sum),
      .casc_out  (casc_out),
      .cell_out  (cell_out)
   );

   always_comb begin
      if (CASC_EN && casc_in) begin
         AST_CASC_PASS: assert (casc_out == 1'b1)
            else $error("cascade input lost"); // R4
      end
      if (cfg_or_en == '0 && (!casc_in || !CASC_EN)) begin
         AST_NO_TERMS_ZERO: assert (casc_out == 1'b0)
            else $error("sum high with no terms"); // R3
      end
      if (cfg_pol == 2'd0 || cfg_pol == 2'd3) begin
         AST_POL_PASS: assert (cell_out == casc_out)
            else $error("polarity zero mode altered sum"); // R5
      end
      if (cfg_pol == 2'd1) begin
         AST_POL_INVERT: assert (cell_out != casc_out)
            else $error("polarity one mode did not invert"); // R5
      end
      if (cfg_fsel == cfg_dsel) begin
         AST_FOLD_INVERSE: assert (fold_out != dat_out)
            else $error("foldback not inverse of term"); // R6
      end
      if (!CASC_EN) begin
         AST_NOCASC_SUM: assert (casc_out == local_sum)
            else $error("cascade leaked when disabled"); // R9
      end
   end

endmodule

// File: tb/sop_cell_bench.sv
module sop_cell_bench;

   localparam int GW = 2;
   localparam int RW = 1;
   localparam int NT = 5;
   localparam int S  = GW + RW;
   localparam int LW = 2 * S;
   localparam int SW = 3;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic [GW-1:0]    glb_in;
   logic [RW-1:0]    rgn_in;
   logic             casc_in;
   logic [NT*LW-1:0] cfg_mask;
   logic [NT-1:0]    cfg_or_en;
   logic [1:0]       cfg_pol;
   logic [SW-1:0]    cfg_xsel, cfg_fsel, cfg_dsel;
   logic cell_out, casc_out, fold_out, dat_out;
   logic nc_cell, nc_casc, nc_fold, nc_dat;

   sop_cell #(.GLB_W(GW), .REG_W(RW), .NT(NT), .CASC_EN(1'b1)) u_sop_cell (
      .glb_in, .rgn_in, .casc_in, .cfg_mask, .cfg_or_en, .cfg_pol,
      .cfg_xsel, .cfg_fsel, .cfg_dsel,
      .cell_out, .casc_out, .fold_out, .dat_out
   );

   sop_cell #(.GLB_W(GW), .REG_W(RW), .NT(NT), .CASC_EN(1'b0)) u_sop_cell_nc (
      .glb_in, .rgn_in, .casc_in, .cfg_mask, .cfg_or_en, .cfg_pol,
      .cfg_xsel, .cfg_fsel, .cfg_dsel,
      .cell_out (nc_cell), .casc_out (nc_casc),
      .fold_out (nc_fold), .dat_out  (nc_dat)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;
   logic [31:0] rng = 32'h1234_5678;

   function automatic logic [31:0] next_rng(input logic [31:0] x);
      logic [31:0] y;
      y = x ^ (x << 13);
      y = y ^ (y >> 17);
      y = y ^ (y << 5);
      return y;
   endfunction

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b (mask=%h en=%b pol=%0d sig=%b%b casc=%b)",
                  req, act, exp, cfg_mask, cfg_or_en, cfg_pol, rgn_in, glb_in, casc_in);
      end
   endtask

   function automatic logic [NT-1:0] model_terms();
      logic [S-1:0]  sig;
      logic [LW-1:0] lit;
      logic [NT-1:0] t;
      sig = {rgn_in, glb_in};
      for (int i = 0; i < S; i++) begin
         lit[i]     = sig[i];
         lit[S + i] = ~sig[i];
      end
      for (int k = 0; k < NT; k++) begin
         t[k] = 1'b1;
         for (int i = 0; i < LW; i++)
            if (cfg_mask[k*LW + i] && !lit[i]) t[k] = 1'b0;
      end
      return t;
   endfunction

   function automatic logic pick(input logic [NT-1:0] t, input logic [SW-1:0] s);
      return (int'(s) < NT) ? t[s] : 1'b0;
   endfunction

   // sweep all signal and cascade values for the present configuration
   task automatic sweep();
      logic [NT-1:0] t;
      logic sum, co, xb;
      for (int v = 0; v < 16; v++) begin
         @(posedge clk);
         {casc_in, rgn_in, glb_in} = v[3:0];
         @(negedge clk);
         t   = model_terms();
         sum = |(t & cfg_or_en);                     // R1 R2 R3
         co  = sum | casc_in;                        // R4
         case (cfg_pol)
            2'd1:    xb = 1'b1;
            2'd2:    xb = pick(t, cfg_xsel);
            default: xb = 1'b0;
         endcase
         check("R4 casc_out", casc_out, co);
         check("R5 cell_out", cell_out, co ^ xb);
         check("R6 R8 fold_out", fold_out, ~pick(t, cfg_fsel));
         check("R7 R8 dat_out", dat_out, pick(t, cfg_dsel));
         check("R9 casc_out no cascade", nc_casc, sum);
         check("R9 cell_out no cascade", nc_cell, sum ^ xb);
      end
   endtask

   initial begin
      glb_in = '0; rgn_in = '0; casc_in = 1'b0;
      cfg_mask = '0; cfg_or_en = '0; cfg_pol = 2'd0;
      cfg_xsel = '0; cfg_fsel = '0; cfg_dsel = '0;
      @(negedge clk);
      // all-zero configuration: no terms in the sum, empty masks are high
      check("R3 reset sum low", casc_out, 1'b0);
      check("R2 empty term on data", dat_out, 1'b1);
      check("R6 fold of empty term", fold_out, 1'b0);

      // R2: empty masks, all terms enabled -> sum high for every input
      cfg_or_en = '1;
      sweep();

      // R1: single-literal masks, one term each, both polarities
      for (int l = 0; l < LW; l++) begin
         cfg_mask  = '0;
         cfg_mask[l] = 1'b1;
         cfg_or_en = 5'b00001;
         cfg_pol   = 2'(l % 2);
         sweep();
      end

      // R7: term steered out of the sum still reaches the data output
      cfg_mask  = '0;
      cfg_mask[LW*3 + 0] = 1'b1;
      cfg_or_en = 5'b10111;
      cfg_dsel  = 3'd3;
      cfg_fsel  = 3'd3;
      sweep();

      // R8: out-of-range selects
      cfg_dsel = 3'd6; cfg_fsel = 3'd7; cfg_xsel = 3'd5; cfg_pol = 2'd2;
      sweep();

      // pseudo-random configurations with sparse masks, all modes
      for (int c = 0; c < 300; c++) begin
         logic [31:0] a, b;
         rng = next_rng(rng); a = rng;
         rng = next_rng(rng); b = rng;
         cfg_mask  = a[29:0] & b[29:0];
         rng = next_rng(rng);
         cfg_or_en = rng[4:0];
         cfg_pol   = rng[6:5];
         cfg_xsel  = rng[9:7];
         cfg_fsel  = rng[12:10];
         cfg_dsel  = (c % 4 == 0) ? rng[12:10] : rng[15:13];
         sweep();
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

endmodule